// File: doc/BRIEF.md
# Real-Time Clock Divider and Update Sequencer

This block paces a real-time clock. It counts a 32.768 kHz timebase, supplied as a one-cycle enable `tick_en` in the fast clock domain, through a binary divider chain. Once per second it issues a one-cycle update pulse to the time-of-day counter and to the alarm compare logic. From the same chain it derives a periodic-interrupt pulse whose rate is set by software. It also owns the control register that selects divider mode and periodic rate. That register carries a read-only update-in-progress flag, which tells software that the time registers are about to change.

Software stops the clock by writing a non-run divider code. This parks the chain at its half-second point, so the first update after restart arrives half a second after the run code is written. Every later update follows one second after the one before it. A set-hold input, driven by the time-counter block while software is loading new time values, suppresses the update pulses. During set-hold the chain keeps counting, so the one-second phase is kept.

Top module: `rtc_update_seq`

## Requirements
- R1: While the divider field (control register bits 6:4) holds any value other than 3'b010, the chain is held. No update pulse and no periodic pulse appear, and the UIP bit reads 0. Releasing the hold restarts the chain from its half-second point.
- R2: Divider code 3'b010 runs the chain. The chain advances by one step on each clock edge where `tick_en` is 1 and ignores edges where it is 0.
- R3: The first update pulse appears 2^(DIV_W-1) ticks after the run code is written, which is 16384 at the defaults. Each later update pulse follows 2^DIV_W ticks after the previous one.
- R4: The UIP flag (register bit 7 and the `uip` port) is 1 during the UIP_HOLD tick periods that end at an update, which is 8 by default, and is 0 at all other times. It drops in the same cycle that the update pulse appears.
- R5: `update_pulse` lasts a single clock cycle. `update_ended` is high in exactly the same cycles.
- R6: Rate code n in register bits 3:0 gives a single-cycle periodic pulse every 2^(n-1) ticks for n from 3 to 15. Codes 1 and 2 give 128 and 256 ticks. Code 0 produces no periodic pulse. After a restart, the first periodic pulse comes one full period after the run code is written.
- R7: While `set_hold` is 1, neither `update_pulse` nor `update_ended` is raised. The chain keeps counting, so the next update after `set_hold` falls keeps the one-second phase.
- R8: Register reads return {UIP, divider field, rate field}. Bits 6:0 read back as last written, and bit 7 of a write is ignored. The register resets to 8'h00.
- R9: Rewriting the register with a run code during the UIP window does not disturb the sequence. UIP still drops, and the update still appears, on the scheduled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz timebase rate |
| rega_wr | input | 1 | Write strobe for the control register |
| rega_wdata | input | 8 | Write data: bits 6:4 divider field, bits 3:0 rate field |
| set_hold | input | 1 | Suppresses update pulses while time is being loaded |
| rega_rdata | output | 8 | Read value {UIP, divider field, rate field} |
| uip | output | 1 | Update in progress |
| update_pulse | output | 1 | One-cycle pulse to the time counter and alarm logic |
| update_ended | output | 1 | One-cycle update-ended flag pulse |
| periodic_pulse | output | 1 | One-cycle periodic-interrupt flag pulse |

## Verification
A register write takes effect at the edge that captures it. The chain starts counting on the first tick edge after that capture. Update and periodic pulses are registered, so each one is visible in the cycle after the tick edge that completes its period. UIP is decoded from the chain phase, so it rises and falls in the cycle after the corresponding tick edges. The bench counts clock edges, or issued ticks, from the write edge, samples every output at the falling clock edge, and compares the edge index of each observed event with the tick count that the requirements predict.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

  localparam logic [2:0] DIV_CODE_RUN = 3'b010;

  typedef struct packed {
    logic [2:0] div;
    logic [3:0] rate;
  } ctrl_reg_t;

  function automatic logic div_runs(input logic [2:0] code);
    return code == DIV_CODE_RUN;
  endfunction

  // log2 of the periodic interval in ticks; code 0 is handled by the caller
  function automatic int rate_shift(input logic [3:0] code, input int max_shift);
    int c;
    int s;
    c = int'(code);
    if (c == 0)      s = 0;
    else if (c < 3)  s = c + 6;
    else             s = c - 1;
    if (s > max_shift) s = max_shift;
    return s;
  endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [2:0] div_code,
  output logic [3:0] rate_code
);
  ctrl_reg_t ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr) begin
      ctrl_q <= ctrl_reg_t'(wdata[6:0]);
    end
  end

  assign div_code  = ctrl_q.div;
  assign rate_code = ctrl_q.rate;
endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
  parameter int DIV_W    = 15,
  parameter int UIP_HOLD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             set_hold,
  output logic [DIV_W-1:0] phase,
  output logic             uip,
  output logic             upd,
  output logic             uf
);
  localparam logic [DIV_W-1:0] HALF      = {1'b1, {(DIV_W-1){1'b0}}};
  localparam logic [DIV_W-1:0] LAST      = '1;
  localparam logic [DIV_W-1:0] UIP_START = LAST - DIV_W'(UIP_HOLD - 1);

  logic [DIV_W-1:0] phase_q;
  logic             wrap_now;

  assign wrap_now = run && tick_en && (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= HALF;
      upd     <= 1'b0;
      uf      <= 1'b0;
    end else begin
      upd <= wrap_now && !set_hold;
      uf  <= wrap_now && !set_hold;
      if (!run) begin
        phase_q <= HALF;
      end else if (tick_en) begin
        phase_q <= phase_q + DIV_W'(1);
      end
    end
  end

  assign phase = phase_q;
  assign uip   = run && (phase_q >= UIP_START);
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic
  import rtc_seq_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic [3:0]       rate_code,
  input  logic [DIV_W-1:0] phase,
  output logic             pf
);
  logic [DIV_W-1:0] tap_mask;
  logic             rate_on;
  logic             tap_hit;
  int               shift;

  always_comb begin
    shift = rate_shift(rate_code, DIV_W - 1);
    for (int i = 0; i < DIV_W; i++) begin
      tap_mask[i] = (i < shift);
    end
  end

  assign rate_on = (rate_code != 4'd0);
  assign tap_hit = run && tick_en && rate_on && ((phase & tap_mask) == tap_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) pf <= 1'b0;
    else        pf <= tap_hit;
  end
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
  import rtc_seq_pkg::*;
#(
  parameter int DIV_W    = 15,
  parameter int UIP_HOLD = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       rega_wr,
  input  logic [7:0] rega_wdata,
  input  logic       set_hold,
  output logic [7:0] rega_rdata,
  output logic       uip,
  output logic       update_pulse,
  output logic       update_ended,
  output logic       periodic_pulse
);
  logic [2:0]       div_code;
  logic [3:0]       rate_code;
  logic             chain_run;
  logic [DIV_W-1:0] chain_phase;

  rtc_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (rega_wr),
    .wdata     (rega_wdata),
    .div_code  (div_code),
    .rate_code (rate_code)
  );

  assign chain_run = div_runs(div_code);

  rtc_div_chain #(.DIV_W(DIV_W), .UIP_HOLD(UIP_HOLD)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .run      (chain_run),
    .set_hold (set_hold),
    .phase    (chain_phase),
    .uip      (uip),
    .upd      (update_pulse),
    .uf       (update_ended)
  );

  rtc_periodic #(.DIV_W(DIV_W)) u_per (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .run       (chain_run),
    .rate_code (rate_code),
    .phase     (chain_phase),
    .pf        (periodic_pulse)
  );

  assign rega_rdata = {uip, div_code, rate_code};
endmodule

// File: rtl/rtc_update_seq_chk.sv
module rtc_update_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       set_hold,
  input logic [7:0] rega_rdata,
  input logic       uip,
  input logic       update_pulse,
  input logic       update_ended,
  input logic       periodic_pulse,
  input logic       chain_run
);
  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_run |=> (!update_pulse && !periodic_pulse)); // R1

  AST_UPD_AFTER_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> $past(uip)); // R4

  AST_UIP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> !uip); // R4

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |=> (!update_pulse && !update_ended)); // R5

  AST_SET_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_hold) |-> (!update_pulse && !update_ended)); // R7

  AST_RATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rega_rdata[3:0]) == 4'd0) |-> !periodic_pulse); // R6
endmodule

bind rtc_update_seq rtc_update_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .set_hold       (set_hold),
  .rega_rdata     (rega_rdata),
  .uip            (uip),
  .update_pulse   (update_pulse),
  .update_ended   (update_ended),
  .periodic_pulse (periodic_pulse),
  .chain_run      (chain_run)
);

// File: tb/tb_rtc_update_seq.sv
`timescale 1ns/1ps
module tb_rtc_update_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       rega_wr = 1'b0;
  logic [7:0] rega_wdata = 8'h00;
  logic       set_hold = 1'b0;
  logic [7:0] rega_rdata;
  logic       uip, update_pulse, update_ended, periodic_pulse;

  int n_tests = 0;
  int n_fail  = 0;

  rtc_update_seq dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rega_wr(rega_wr),
    .rega_wdata(rega_wdata), .set_hold(set_hold), .rega_rdata(rega_rdata),
    .uip(uip), .update_pulse(update_pulse), .update_ended(update_ended),
    .periodic_pulse(periodic_pulse)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ticks between periodic pulses, restated from the requirement
  function automatic int period_ticks(input int code);
    if (code == 0) return 0;
    if (code == 1) return 128;
    if (code == 2) return 256;
    return 2 ** (code - 1);
  endfunction

  task automatic write_a(input logic [7:0] v);
    @(negedge clk);
    rega_wr = 1'b1;
    rega_wdata = v;
    @(negedge clk);
    rega_wr = 1'b0;
  endtask

  initial begin
    #(5.0 * 195000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cnt_upd, cnt_uf_mis, cnt_pf, cnt_uip, first_upd, second_upd, first_uip, first_pf;
    int pf_a, pf_b;
    void'($urandom(32'h0000_5EED));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset value
    check("R8", "reset rdata", int'(rega_rdata), 8'h00);
    check("R1", "reset uip", int'(uip), 0);

    // R1/R8: hold code with bit 7 set in the write
    write_a(8'hF3);
    check("R8", "bit7 ignored", int'(rega_rdata), 8'h73);
    cnt_upd = 0; cnt_pf = 0; cnt_uip = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      cnt_upd += int'(update_pulse);
      cnt_pf  += int'(periodic_pulse);
      cnt_uip += int'(uip);
    end
    check("R1", "held updates", cnt_upd, 0);
    check("R1", "held periodic", cnt_pf, 0);
    check("R1", "held uip", cnt_uip, 0);

    // R2/R3/R4/R5/R6/R9: run with rate 13
    write_a(8'h2D);
    cnt_upd = 0; cnt_uf_mis = 0; cnt_pf = 0; cnt_uip = 0;
    first_upd = -1; second_upd = -1; first_uip = -1; first_pf = -1;
    for (int k = 1; k <= 49160; k++) begin
      if (k == 49151) begin rega_wr = 1'b1; rega_wdata = 8'h2D; end
      else rega_wr = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (k == 1) check("R8", "readback run", int'(rega_rdata), 8'h2D);
      if (k == 16380) check("R4", "rdata in window", int'(rega_rdata), 8'hAD);
      if (update_pulse) begin
        cnt_upd++;
        if (first_upd < 0) first_upd = k; else if (second_upd < 0) second_upd = k;
      end
      if (update_pulse !== update_ended) cnt_uf_mis++;
      if (uip) begin cnt_uip++; if (first_uip < 0) first_uip = k; end
      if (periodic_pulse && k <= 49152) begin
        cnt_pf++;
        if (first_pf < 0) first_pf = k;
      end
    end
    rega_wr = 1'b0;
    check("R3", "first update edge", first_upd, 16384);
    check("R9", "second update edge", second_upd, 49152);
    check("R3", "update count", cnt_upd, 2);
    check("R5", "uf mismatch cycles", cnt_uf_mis, 0);
    check("R4", "uip first edge", first_uip, 16376);
    check("R4", "uip cycles", cnt_uip, 16);
    check("R6", "first periodic rate13", first_pf, period_ticks(13));
    check("R6", "periodic count rate13", cnt_pf, 12);

    // R6: rate 15 spacing
    write_a(8'h2F);
    pf_a = -1; pf_b = -1;
    for (int k = 1; k <= 40000 && pf_b < 0; k++) begin
      @(negedge clk);
      if (periodic_pulse) begin if (pf_a < 0) pf_a = k; else pf_b = k; end
    end
    check("R6", "rate15 spacing", pf_b - pf_a, period_ticks(15));

    // R7: set_hold blocks updates while chain keeps counting
    set_hold = 1'b1;
    write_a(8'h7F);
    write_a(8'h2F);
    cnt_upd = 0; cnt_pf = 0; cnt_uf_mis = 0; first_upd = -1;
    for (int k = 1; k <= 49160; k++) begin
      if (k == 16401) set_hold = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (k <= 16400) begin
        cnt_uf_mis += int'(update_pulse) + int'(update_ended);
        cnt_pf += int'(periodic_pulse);
      end else if (update_pulse) begin
        cnt_upd++;
        if (first_upd < 0) first_upd = k;
      end
    end
    check("R7", "pulses under set_hold", cnt_uf_mis, 0);
    check("R7", "periodic under set_hold", cnt_pf, 1);
    check("R7", "phase kept after set_hold", first_upd, 49152);
    check("R7", "updates after set_hold", cnt_upd, 1);

    // R2/R6: random tick gaps and random rate codes
    for (int t = 0; t < 10; t++) begin
      int code, ticks, seen;
      code = (t == 9) ? 0 : $urandom_range(1, 9);
      write_a(8'h70 | 8'(code));
      write_a(8'h20 | 8'(code));
      ticks = 0; seen = 0;
      for (int c = 0; c < 1200 && seen == 0; c++) begin
        tick_en = 1'($urandom_range(0, 1));
        @(posedge clk);
        if (tick_en) ticks++;
        @(negedge clk);
        if (periodic_pulse) seen = 1;
      end
      if (code == 0) check("R6", "rate0 silent", seen, 0);
      else check("R2", $sformatf("ticks to pulse code %0d", code), ticks, period_ticks(code));
    end
    tick_en = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule